// File: doc/BRIEF.md
# Timer Interrupt Pending Logic

This block owns the two timer-pending flags and the software-visible interrupt pending and enable words of a 32-bit hart. It holds two 64-bit compare values, one for the machine timer and one for the supervisor timer. On every clock it checks a free-running 64-bit time value, given as two 32-bit halves, against both of them. Each result lands in its fixed bit of the pending word, and software cannot overwrite either one.

Software reaches the block through a plain CSR strobe with an address, write data and the current privilege. The pending and enable words take writes through a machine view and a narrower supervisor view, each with a fixed mask. The supervisor compare register is guarded by a timer-enable bit held in the machine counter-enable word. All pins are plain control and status signals with no valid/ready handshake. An access is taken in the cycle its strobe is high, and nothing in the block ever stalls.

Top module: `tip_timer_irq`

## Requirements
- R1: After reset, `irq_pending` and `irq_enable` are zero, `csr_illegal` is low, and both compare values are all ones. No timer bit is set for any time value below all ones.
- R2: A timer is due when the time high half is greater than the compare high half, or when the high halves are equal and the time low half is greater than or equal to the compare low half.
- R3: The machine timer result is `irq_pending` bit 7 and the supervisor timer result is bit 5. Both are recomputed on every clock edge, so a change of the time inputs shows after one edge.
- R4: A write to address 0x344 (full pending view) changes only bits 9 and 1. Bits 7 and 5 stay hardware-driven, and every other bit stays zero.
- R5: A write to address 0x144 (supervisor pending view) changes only bit 1, and bit 9 keeps its value.
- R6: A write to address 0x304 (full enable view) stores the data ANDed with 0x0000_0AA2, which keeps bits 11, 9, 7, 5 and 1.
- R7: A write to address 0x104 (supervisor enable view) replaces bits 9, 5 and 1 and leaves bits 11 and 7 as they were.
- R8: The machine compare halves sit at 0x7C0 (low) and 0x7C1 (high), and the supervisor halves at 0x14D (low) and 0x15D (high). The pending bit reflects a new compare value no more than two edges after the write strobe.
- R9: Privilege encoding is 2'b11 machine, 2'b01 supervisor and 2'b00 user. A read or write of 0x14D or 0x15D below machine privilege while the timer-enable bit is clear raises `csr_illegal` in the same cycle as the strobe, and a write so flagged has no effect.
- R10: The timer-enable bit is bit 1 of a write to address 0x306 and resets to 0. Machine-privilege accesses are never flagged, and when the bit is set, supervisor accesses are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_lo | input | 32 | Low half of the 64-bit time value |
| time_hi | input | 32 | High half of the 64-bit time value |
| csr_we | input | 1 | CSR write strobe |
| csr_re | input | 1 | CSR read strobe, used only for the access check |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| priv | input | 2 | Current privilege level |
| irq_pending | output | 32 | Interrupt pending word |
| irq_enable | output | 32 | Interrupt enable word |
| csr_illegal | output | 1 | Access rejected this cycle |

## Verification
If a compare half is stored in the wrong slot or not stored at all, the wrong timer bit rises or falls. This shows at `irq_pending` within two edges of the write or of the next time step that crosses the boundary. A bad mask in one of the four views shows on the next edge as an extra or missing bit in `irq_pending` or `irq_enable`. A wrong timer-enable bit shows in the same cycle as a flipped `csr_illegal`, and a write that was dropped or leaked through shows later as a timer bit in the wrong state. The reference model is compared against all three outputs after every edge, so each of these faults is reported in the cycle it first appears.

// File: rtl/tip_pkg.sv
package tip_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned AW   = 12;

  localparam logic [AW-1:0] A_MPEND  = 12'h344;
  localparam logic [AW-1:0] A_SPEND  = 12'h144;
  localparam logic [AW-1:0] A_MENAB  = 12'h304;
  localparam logic [AW-1:0] A_SENAB  = 12'h104;
  localparam logic [AW-1:0] A_CNTEN  = 12'h306;
  localparam logic [AW-1:0] A_MCMP_L = 12'h7C0;
  localparam logic [AW-1:0] A_MCMP_H = 12'h7C1;
  localparam logic [AW-1:0] A_SCMP_L = 12'h14D;
  localparam logic [AW-1:0] A_SCMP_H = 12'h15D;

  localparam logic [XLEN-1:0] MPEND_WMASK = 32'h0000_0202;
  localparam logic [XLEN-1:0] SPEND_WMASK = 32'h0000_0002;
  localparam logic [XLEN-1:0] MENAB_WMASK = 32'h0000_0AA2;
  localparam logic [XLEN-1:0] SENAB_WMASK = 32'h0000_0222;

  localparam int unsigned MT_BIT  = 7;
  localparam int unsigned ST_BIT  = 5;
  localparam int unsigned TEN_BIT = 1;

  localparam logic [1:0] PRV_U = 2'b00;
  localparam logic [1:0] PRV_S = 2'b01;
  localparam logic [1:0] PRV_M = 2'b11;
endpackage

// File: rtl/tip_cmp_slot.sv
module tip_cmp_slot #(
  parameter int unsigned W = 32,
  parameter int unsigned AW = 12,
  parameter logic [AW-1:0] LO_ADDR = '0,
  parameter logic [AW-1:0] HI_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  t_lo,
  input  logic [W-1:0]  t_hi,
  output logic          due_q
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] cmp_q;
  logic          due_now;

  always_comb begin
    due_now = (t_hi > cmp_q[DW-1:W]) ||
              ((t_hi == cmp_q[DW-1:W]) && (t_lo >= cmp_q[W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '1;
      due_q <= 1'b0;
    end else begin
      if (wr_en && addr == LO_ADDR) cmp_q[W-1:0]  <= wdata;
      if (wr_en && addr == HI_ADDR) cmp_q[DW-1:W] <= wdata;
      due_q <= due_now;
    end
  end

  // R8: compare storage only moves on an accepted write strobe
  p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp_q));

  // R1: an all-ones compare never makes a timer due for a smaller time
  p_ones_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmp_q) == '1 && {$past(t_hi), $past(t_lo)} != '1) |-> !due_q);
endmodule

// File: rtl/tip_irq_regs.sv
module tip_irq_regs
  import tip_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  sw_pend,
  output logic [W-1:0]  enab
);
  logic [W-1:0] pend_d, enab_d;

  always_comb begin
    pend_d = sw_pend;
    enab_d = enab;
    if (we) begin
      unique case (addr)
        A_MPEND: pend_d = (sw_pend & ~MPEND_WMASK) | (wdata & MPEND_WMASK);
        A_SPEND: pend_d = (sw_pend & ~SPEND_WMASK) | (wdata & SPEND_WMASK);
        A_MENAB: enab_d = wdata & MENAB_WMASK;
        A_SENAB: enab_d = (enab & ~SENAB_WMASK) | (wdata & SENAB_WMASK);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_pend <= '0;
      enab    <= '0;
    end else begin
      sw_pend <= pend_d;
      enab    <= enab_d;
    end
  end

  // R4: without a write strobe the software-owned words hold
  p_sw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(sw_pend) && $stable(enab)));
endmodule

// File: rtl/tip_timer_irq.sv
module tip_timer_irq
  import tip_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] time_lo,
  input  logic [XLEN-1:0] time_hi,
  input  logic            csr_we,
  input  logic            csr_re,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      priv,
  output logic [XLEN-1:0] irq_pending,
  output logic [XLEN-1:0] irq_enable,
  output logic            csr_illegal
);
  localparam int unsigned NSLOT = 2;

  logic             ten_q;
  logic             scmp_hit;
  logic             we_ok;
  logic [NSLOT-1:0] due_all;
  logic [XLEN-1:0]  sw_pend;

  always_comb begin
    scmp_hit    = (csr_addr == A_SCMP_L) || (csr_addr == A_SCMP_H);
    csr_illegal = (csr_we || csr_re) && scmp_hit && (priv != PRV_M) && !ten_q;
    we_ok       = csr_we && !csr_illegal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            ten_q <= 1'b0;
    else if (we_ok && csr_addr == A_CNTEN) ten_q <= csr_wdata[TEN_BIT];
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [AW-1:0] LO_A = (i == 0) ? A_MCMP_L : A_SCMP_L;
    localparam logic [AW-1:0] HI_A = (i == 0) ? A_MCMP_H : A_SCMP_H;
    tip_cmp_slot #(.W(XLEN), .AW(AW), .LO_ADDR(LO_A), .HI_ADDR(HI_A)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (we_ok),
      .addr  (csr_addr),
      .wdata (csr_wdata),
      .t_lo  (time_lo),
      .t_hi  (time_hi),
      .due_q (due_all[i])
    );
  end

  tip_irq_regs #(.W(XLEN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we_ok),
    .addr    (csr_addr),
    .wdata   (csr_wdata),
    .sw_pend (sw_pend),
    .enab    (irq_enable)
  );

  always_comb begin
    irq_pending         = sw_pend;
    irq_pending[MT_BIT] = due_all[0];
    irq_pending[ST_BIT] = due_all[1];
  end

  // R10: machine privilege is never rejected
  p_mach_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (priv != PRV_M));

  // R10: the enable bit only rises after a counter-enable write
  p_ten_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ten_q) |-> ($past(csr_we) && $past(csr_addr) == A_CNTEN));

  // R9: a flagged access never coincides with a granted enable bit
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal && csr_we) |=> !$rose(ten_q));
endmodule

// File: tb/tip_timer_irq_test.sv
`timescale 1ns/100ps
module tip_timer_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_lo = '0, time_hi = '0;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [1:0]  priv = 2'b11;
  logic [31:0] irq_pending, irq_enable;
  logic        csr_illegal;

  always #2.5 clk = ~clk;

  tip_timer_irq uut (
    .clk(clk), .rst_n(rst_n), .time_lo(time_lo), .time_hi(time_hi),
    .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .priv(priv), .irq_pending(irq_pending), .irq_enable(irq_enable),
    .csr_illegal(csr_illegal)
  );

  int applied = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_mcmp, m_scmp;
  logic        m_ten, m_pm, m_ps;
  logic [31:0] m_sw, m_en;

  function automatic logic [31:0] exp_pend();
    logic [31:0] v;
    v = m_sw;
    v[7] = m_pm;
    v[5] = m_ps;
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic re, logic [11:0] a,
                      logic [31:0] d, logic [1:0] pv, logic [63:0] tv);
    logic ill;
    csr_we = we; csr_re = re; csr_addr = a; csr_wdata = d; priv = pv;
    time_hi = tv[63:32]; time_lo = tv[31:0];
    ill = (we || re) && (a == 12'h14D || a == 12'h15D) && pv != 2'b11 && !m_ten;
    #1;
    chk(tag, "illegal", {31'd0, csr_illegal}, {31'd0, ill});
    @(posedge clk);
    m_pm = (tv >= m_mcmp);
    m_ps = (tv >= m_scmp);
    if (we && !ill) begin
      case (a)
        12'h344: m_sw = (m_sw & ~32'h202) | (d & 32'h202);
        12'h144: m_sw = (m_sw & ~32'h2) | (d & 32'h2);
        12'h304: m_en = d & 32'hAA2;
        12'h104: m_en = (m_en & ~32'h222) | (d & 32'h222);
        12'h306: m_ten = d[1];
        12'h7C0: m_mcmp[31:0] = d;
        12'h7C1: m_mcmp[63:32] = d;
        12'h14D: m_scmp[31:0] = d;
        12'h15D: m_scmp[63:32] = d;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag, "pending", irq_pending, exp_pend());
    chk(tag, "enable", irq_enable, m_en);
  endtask

  task automatic idle(string tag, logic [63:0] tv);
    step(tag, 1'b0, 1'b0, 12'h000, 32'h0, 2'b11, tv);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    m_mcmp = '1; m_scmp = '1; m_ten = 0; m_pm = 0; m_ps = 0; m_sw = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    chk("R1", "pending", irq_pending, 32'h0);
    chk("R1", "enable", irq_enable, 32'h0);
    idle("R1", 64'hFFFF_FFFF_FFFF_FFFE);
    idle("R1", 64'h0);

    // R4, R5, R6, R7: masked software views
    step("R4", 1, 0, 12'h344, 32'hFFFF_FFFF, 2'b11, 64'h0);
    step("R5", 1, 0, 12'h144, 32'h0, 2'b01, 64'h0);
    step("R5", 1, 0, 12'h144, 32'hFFFF_FFFF, 2'b01, 64'h0);
    step("R6", 1, 0, 12'h304, 32'hFFFF_FFFF, 2'b11, 64'h0);
    step("R7", 1, 0, 12'h104, 32'h0, 2'b01, 64'h0);
    step("R7", 1, 0, 12'h104, 32'h0000_0020, 2'b01, 64'h0);
    step("R6", 1, 0, 12'h304, 32'h0000_0880, 2'b11, 64'h0);

    // R2, R3, R8: machine compare boundaries
    step("R8", 1, 0, 12'h7C0, 32'h0000_0100, 2'b11, 64'h0);
    step("R8", 1, 0, 12'h7C1, 32'h0000_0005, 2'b11, 64'h0);
    idle("R2", 64'h0000_0005_0000_00FF);
    idle("R2", 64'h0000_0005_0000_0100);
    idle("R3", 64'h0000_0004_FFFF_FFFF);
    idle("R2", 64'h0000_0006_0000_0000);
    idle("R3", 64'h0000_0006_0000_0000);

    // R4: writes cannot clear hardware-owned bit 7
    step("R4", 1, 0, 12'h344, 32'h0, 2'b11, 64'h0000_0006_0000_0000);
    idle("R4", 64'h0000_0006_0000_0000);

    // R9: supervisor access while the enable bit is clear
    step("R9", 1, 0, 12'h14D, 32'h0, 2'b01, 64'h0000_0006_0000_0000);
    step("R9", 1, 0, 12'h15D, 32'h0, 2'b01, 64'h0000_0006_0000_0000);
    step("R9", 0, 1, 12'h14D, 32'h0, 2'b00, 64'h0000_0006_0000_0000);
    idle("R9", 64'h0000_0006_0000_0000);

    // R10: machine access ignores the enable bit, then the bit is granted
    step("R10", 1, 0, 12'h15D, 32'h0000_0007, 2'b11, 64'h0000_0006_0000_0000);
    step("R10", 1, 0, 12'h306, 32'h0000_0002, 2'b11, 64'h0000_0006_0000_0000);
    step("R10", 1, 0, 12'h14D, 32'h0000_0010, 2'b01, 64'h0000_0006_0000_0000);
    step("R8", 1, 0, 12'h15D, 32'h0000_0006, 2'b01, 64'h0000_0006_0000_0000);
    idle("R8", 64'h0000_0006_0000_0010);
    idle("R3", 64'h0000_0006_0000_000F);
    idle("R3", 64'h0000_0007_0000_0000);
    step("R4", 1, 0, 12'h344, 32'h0000_00A0, 2'b11, 64'h0000_0007_0000_0000);

    // R10: clearing the bit blocks supervisor again
    step("R10", 1, 0, 12'h306, 32'hFFFF_FFFD, 2'b11, 64'h0);
    step("R9", 1, 0, 12'h14D, 32'hFFFF_FFFF, 2'b01, 64'h0000_0006_0000_0010);
    idle("R9", 64'h0000_0006_0000_0010);

    // R2: sweep the low half near the supervisor boundary
    for (int k = 0; k < 8; k++) idle("R2", 64'h0000_0006_0000_000C + 64'(k));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule